// File: doc/BRIEF.md
# Serial NOR Flash Read Sequencer

This block runs single read transactions against an external serial NOR flash. The host supplies a 24-bit byte address, a byte count, a lane mode and a clock divider, then pulses a start strobe. The sequencer pulls chip select low and sends an 8-bit read opcode and the 24-bit address on data line 0. It then releases all data lines for a fixed run of dummy clocks and gathers the returned bytes over one, four or eight lanes. The opcode depends on the lane mode. All fields are single data rate.

Finished bytes leave on a valid/ready byte stream. A byte stays on `m_data` with `m_valid` high until the consumer raises `m_ready` in the same cycle. The sequencer never drops a byte. If the holding register is still full when the next byte is about to complete, the serial clock stops low until the consumer takes the waiting byte. A flash in clock mode 0 accepts this pause. After the last byte has been sampled and accepted, chip select rises and `done` pulses for one cycle.

The serial clock idles low. Outgoing bits change on its falling edge. Incoming bits are sampled on its rising edge. Each half period lasts `clk_div + 1` system clocks, so the host can keep the serial clock at or below the flash's limit (50 MHz).

Top module: `sfr_seq`

## Requirements
- R1: After reset and whenever no transaction is running: `cs_n` is 1, `sck` is 0, `io_oe` is all zeros, and `busy`, `done` and `m_valid` are 0.
- R2: The opcode depends on `lane_mode`: 2'b00 sends 0x0B (one lane), 2'b01 sends 0x6B (four lanes), 2'b10 sends 0x8B (eight lanes). 2'b11 behaves exactly like 2'b00.
- R3: The first 32 rising edges of `sck` carry the opcode and then `rd_addr`, MSB first, on `io_out[0]`. During these edges `io_oe` is 8'h01.
- R4: Exactly 8 dummy rising edges follow the address. `io_oe` goes to all zeros on the falling edge after the 32nd rising edge and stays there until `cs_n` rises. A transaction of N bytes therefore has 40 + N×S rising edges, where S is 8, 2 or 1 samples per byte.
- R5: Lane mapping of the data phase:
  - One-lane mode takes one bit per rising edge from `io_in[1]`, MSB first.
  - Four-lane mode takes `io_in[3:0]` on each rising edge, with bits [7:4] of a byte first and bits [3:0] second.
  - Eight-lane mode takes the whole byte on one rising edge, with `io_in[n]` as bit n.
  - Bytes come from ascending addresses, starting at `rd_addr` and wrapping modulo 2^24.
- R6: Each high and each low half period of `sck` lasts `clk_div + 1` system clocks, except while a stall is in effect (R8). The divider value is captured at start.
- R7: `m_data` holds steady while `m_valid` is 1 and `m_ready` is 0. Exactly `rd_len` bytes are delivered, in address order.
- R8: Back-pressure stalls the serial clock low before the edge that would complete a byte while the holding register is full. No byte is lost or duplicated.
- R9: Once the last byte has been accepted, `cs_n` rises and `done` pulses for one cycle in the same cycle, with `busy` low. When the consumer is always ready, `cs_n` rises 3×(`clk_div`+1) system clocks after the last rising edge of `sck`.
- R10: A start pulse is ignored in two cases: while `busy` is 1, or when `rd_len` is 0. Such a pulse changes neither the running transfer nor the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read (one-cycle pulse) |
| lane_mode | input | 2 | Data lane mode: 0/3 one lane, 1 four lanes, 2 eight lanes |
| rd_addr | input | 24 | Flash byte address of the first byte |
| rd_len | input | 16 | Number of bytes to read (0 is ignored) |
| clk_div | input | 8 | Serial clock half period minus one, in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| m_valid | output | 1 | Stream byte available |
| m_ready | input | 1 | Consumer accepts the stream byte |
| m_data | output | 8 | Stream byte |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock to the flash |
| io_out | output | 8 | Values driven on the data lines |
| io_oe | output | 8 | Per-lane output enable (1 = driven) |
| io_in | input | 8 | Values sampled from the data lines |

## Verification
The bench aims at these corner cases:
- Four-lane nibble order. A design that swapped the nibbles would return bytes with their halves exchanged.
- Lane selection. In one-lane and four-lane modes the unused lanes carry the inverse of the valid bit, so a design that read the wrong lane would take in inverted bits.
- Dummy count. An off-by-one would shift every data sample, and the total rising-edge count would no longer be 40 + N×S.
- Heavy back-pressure in eight-lane mode with the fastest divider. A design that kept clocking while the holding register was full would lose or repeat bytes.
- Reads that wrap past the top of the address space.
- The reserved mode value, which must behave as one-lane.
- A start pulse during a transfer and a zero-length start. A design that honoured either would show a second chip-select fall or a spurious busy period.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HDR,
    PH_DUMMY,
    PH_DATA,
    PH_TAIL
  } phase_e;

  // Read command for each lane mode; the reserved value falls back to one lane.
  function automatic logic [7:0] read_opcode(input logic [1:0] mode);
    case (mode)
      2'd1:    return 8'h6B;
      2'd2:    return 8'h8B;
      default: return 8'h0B;
    endcase
  endfunction

  // Rising edges of the serial clock needed to gather one byte.
  function automatic logic [3:0] samples_per_byte(input logic [1:0] mode);
    case (mode)
      2'd1:    return 4'd2;
      2'd2:    return 4'd1;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sfr_tick.sv
`timescale 1ns/1ps
module sfr_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // One tick per half period; a hold parks the counter at its terminal value.
  assign tick = run && !hold && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || tick)     cnt <= '0;
    else if (cnt != div)       cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/sfr_tx.sv
`timescale 1ns/1ps
module sfr_tx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_o
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign bit_o = sr[W-1];
endmodule

// File: rtl/sfr_rx.sv
`timescale 1ns/1ps
module sfr_rx
  import sfr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] mode,
  input  logic       cap,
  input  logic [7:0] lanes,
  input  logic       m_ready,
  output logic       m_valid,
  output logic [7:0] m_data,
  output logic       last_sample
);
  logic [7:0] acc;
  logic [7:0] nxt;
  logic [3:0] sub;
  logic [3:0] spb;

  assign spb         = samples_per_byte(mode);
  assign last_sample = (sub == spb - 4'd1);

  always_comb begin
    case (mode)
      2'd1:    nxt = {acc[3:0], lanes[3:0]};
      2'd2:    nxt = lanes;
      default: nxt = {acc[6:0], lanes[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      sub     <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (clr) begin
        acc <= '0;
        sub <= '0;
      end else if (cap) begin
        acc <= nxt;
        if (last_sample) begin
          sub     <= '0;
          m_data  <= nxt;
          m_valid <= 1'b1;
        end else begin
          sub <= sub + 4'd1;
        end
      end
    end
  end

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
endmodule

// File: rtl/sfr_seq.sv
`timescale 1ns/1ps
module sfr_seq
  import sfr_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int DIV_W     = 8,
  parameter int DUMMY_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        lane_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  rd_len,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              busy,
  output logic              done,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic              cs_n,
  output logic              sck,
  output logic [7:0]        io_out,
  output logic [7:0]        io_oe,
  input  logic [7:0]        io_in
);
  localparam int HDR_W = 8 + ADDR_W;
  localparam int EC_W  = $clog2(HDR_W + 1);

  phase_e            ph;
  logic [1:0]        mode_q;
  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  left;
  logic [EC_W-1:0]   ecnt;
  logic              tail;
  logic              tick, hold, cap, shift, accept, last_sample, tx_bit, byte_done;
  logic [7:0]        op_q;

  assign busy      = (ph != PH_IDLE);
  assign accept    = (ph == PH_IDLE) && start && (rd_len != '0);
  assign cap       = tick && !sck && (ph == PH_DATA);
  assign byte_done = cap && last_sample;
  assign shift     = tick && sck && (ph == PH_HDR) && (ecnt != EC_W'(HDR_W));
  assign hold      = ((ph == PH_DATA) && !sck && last_sample && m_valid) ||
                     ((ph == PH_TAIL) && m_valid);
  assign io_out    = {7'b0, tx_bit};
  assign op_q      = read_opcode(mode_q);

  sfr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .hold(hold), .div(div_q), .tick(tick)
  );

  sfr_tx #(.W(HDR_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val({read_opcode(lane_mode), rd_addr}),
    .shift(shift), .bit_o(tx_bit)
  );

  sfr_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept), .mode(mode_q), .cap(cap),
    .lanes(io_in), .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
    .last_sample(last_sample)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
      io_oe  <= '0;
      done   <= 1'b0;
      mode_q <= '0;
      div_q  <= '0;
      left   <= '0;
      ecnt   <= '0;
      tail   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        ph     <= PH_HDR;
        cs_n   <= 1'b0;
        sck    <= 1'b0;
        io_oe  <= 8'h01;
        mode_q <= lane_mode;
        div_q  <= clk_div;
        left   <= rd_len;
        ecnt   <= '0;
        tail   <= 1'b0;
      end else if (tick) begin
        if (ph == PH_TAIL) begin
          if (tail) begin
            ph   <= PH_IDLE;
            cs_n <= 1'b1;
            done <= 1'b1;
          end
          tail <= 1'b1;
        end else if (!sck) begin
          sck <= 1'b1;
          if (ph != PH_DATA) ecnt <= ecnt + EC_W'(1);
          if (byte_done) left <= left - CNT_W'(1);
        end else begin
          sck <= 1'b0;
          case (ph)
            PH_HDR: if (ecnt == EC_W'(HDR_W)) begin
              ph    <= PH_DUMMY;
              ecnt  <= '0;
              io_oe <= '0;
            end
            PH_DUMMY: if (ecnt == EC_W'(DUMMY_CYC)) begin
              ph   <= PH_DATA;
              ecnt <= '0;
            end
            PH_DATA: if (left == '0) ph <= PH_TAIL;
            default: ;
          endcase
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sck && io_oe == '0));

  p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (io_out[0] == op_q[7]));

  p_lines_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DUMMY || ph == PH_DATA || ph == PH_TAIL) |-> (io_oe == '0));

  p_stall_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && hold) |=> $stable(sck));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mode_q) && $stable(div_q)));

  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && rd_len == '0) |=> !busy);
endmodule

// File: tb/tb_sfr_seq.sv
`timescale 1ns/1ps
module tb_sfr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  lane_mode = 2'd0;
  logic [23:0] rd_addr = '0;
  logic [15:0] rd_len = '0;
  logic [7:0]  clk_div = '0;
  logic        busy, done, m_valid, cs_n, sck;
  logic        m_ready = 1'b0;
  logic [7:0]  m_data, io_out, io_oe;
  logic [7:0]  io_in = '0;

  always #4 clk = ~clk;

  sfr_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_mode(lane_mode),
    .rd_addr(rd_addr), .rd_len(rd_len), .clk_div(clk_div), .busy(busy),
    .done(done), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_op(input logic [1:0] m);
    if (m == 2'd1) return 8'h6B;
    if (m == 2'd2) return 8'h8B;
    return 8'h0B;
  endfunction

  function automatic int spb_of(input logic [1:0] m);
    if (m == 2'd1) return 2;
    if (m == 2'd2) return 1;
    return 8;
  endfunction

  function automatic logic [7:0] flash_byte(input logic [23:0] a);
    return (a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16]) + 8'h3D;
  endfunction

  // Flash model: mode 0, shifts in header, drives data after 40 rising edges.
  logic [1:0]  cur_mode = 2'd0;
  logic [23:0] cur_addr = '0;
  int          fl_rise = 0, cs_falls = 0;
  logic [31:0] fl_hdr = '0;
  bit          oe_bad_hdr = 0, oe_bad_rel = 0;
  time         t_r1, t_r2, t_last_rise, t_cs_rise;
  int          m_k, m_s, m_sub;
  logic [7:0]  m_b;
  logic [3:0]  m_nib;
  logic        m_bt;

  always @(negedge cs_n) begin
    fl_rise = 0; fl_hdr = '0; oe_bad_hdr = 0; oe_bad_rel = 0; cs_falls++;
  end

  always @(posedge cs_n) t_cs_rise = $time;

  always @(posedge sck) begin
    if (fl_rise < 32) begin
      fl_hdr = {fl_hdr[30:0], io_out[0]};
      if (io_oe !== 8'h01) oe_bad_hdr = 1;
    end else if (io_oe !== 8'h00) oe_bad_rel = 1;
    if (fl_rise == 0) t_r1 = $time;
    if (fl_rise == 1) t_r2 = $time;
    t_last_rise = $time;
    fl_rise++;
  end

  always @(negedge sck) begin
    if (cs_n === 1'b0 && fl_rise >= 40) begin
      m_k = fl_rise - 40;
      m_s = spb_of(cur_mode);
      m_sub = m_k % m_s;
      m_b = flash_byte(cur_addr + 24'(m_k / m_s));
      case (cur_mode)
        2'd1: begin m_nib = (m_sub == 0) ? m_b[7:4] : m_b[3:0]; io_in <= {~m_nib, m_nib}; end
        2'd2: io_in <= m_b;
        default: begin m_bt = m_b[7 - m_sub]; io_in <= {{6{~m_bt}}, m_bt, ~m_bt}; end
      endcase
    end
  end

  // Consumer: ready decided at negedge, handshake recorded for the next posedge.
  int         ready_pct = 100;
  logic [7:0] rx_buf [0:255];
  int         rx_n = 0, done_seen = 0, rx_at_done = 0;
  bit         done_ok = 0;

  always @(negedge clk) begin
    m_ready = (($urandom % 100) < ready_pct);
    if (m_valid === 1'b1 && m_ready) begin
      rx_buf[rx_n[7:0]] = m_data;
      rx_n++;
    end
    if (done === 1'b1) begin
      done_seen++;
      done_ok = (cs_n === 1'b1) && (busy === 1'b0);
      rx_at_done = rx_n;
    end
  end

  task automatic run_txn(input logic [1:0] md, input logic [23:0] a, input int n,
                         input logic [7:0] dv, input int rp, input bit poke);
    int f0, d0, w;
    longint cyc;
    @(negedge clk);
    cur_mode = md; cur_addr = a; ready_pct = rp; rx_n = 0;
    f0 = cs_falls; d0 = done_seen;
    lane_mode = md; rd_addr = a; rd_len = 16'(n); clk_div = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      chk(busy === 1'b1, "R10 busy before second start", 32'(busy), 32'd1);
      lane_mode = ~md; rd_addr = a ^ 24'h555555; rd_len = 16'(n + 3); clk_div = dv + 8'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done_seen == d0 && w < 20000) begin @(negedge clk); w++; end
    chk(done_seen == d0 + 1, "R9 done pulse seen", 32'(done_seen - d0), 32'd1);
    chk(done_ok, "R9 cs_n high and busy low at done", 32'(done_ok), 32'd1);
    chk(rx_at_done == n, "R7 byte count at done", 32'(rx_at_done), 32'(n));
    for (int i = 0; i < n; i++)
      chk(rx_buf[i] === flash_byte(a + 24'(i)), (rp < 100) ? "R8 byte under back-pressure" : "R5 lane data byte",
          32'(rx_buf[i]), 32'(flash_byte(a + 24'(i))));
    chk(fl_hdr[31:24] == exp_op(md), "R2 opcode", 32'(fl_hdr[31:24]), 32'(exp_op(md)));
    chk(fl_hdr[23:0] == a, "R3 address", 32'(fl_hdr[23:0]), 32'(a));
    chk(!oe_bad_hdr, "R3 oe during header", 32'(oe_bad_hdr), 32'd0);
    chk(!oe_bad_rel, "R4 lines released", 32'(oe_bad_rel), 32'd0);
    chk(fl_rise == 40 + n * spb_of(md), "R4 total rising edges", 32'(fl_rise), 32'(40 + n * spb_of(md)));
    cyc = longint'((t_r2 - t_r1) / 8);
    chk(cyc == 2 * (dv + 1), "R6 sck period", 32'(cyc), 32'(2 * (dv + 1)));
    if (rp == 100) begin
      cyc = longint'((t_cs_rise - t_last_rise) / 8);
      chk(cyc == 3 * (dv + 1), "R9 cs release gap", 32'(cyc), 32'(3 * (dv + 1)));
    end
    chk(cs_falls == f0 + 1, "R10 single chip-select cycle", 32'(cs_falls - f0), 32'd1);
    repeat (10) @(negedge clk);
    chk(busy === 1'b0 && cs_n === 1'b1, "R1 idle after transfer", {30'd0, busy, cs_n}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f0;
    bit saw_busy;
    void'($urandom(32'h5EED1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R1 reset cs_n/sck", {30'd0, cs_n, sck}, 32'd2);
    chk(io_oe === 8'h00, "R1 reset oe", 32'(io_oe), 32'd0);
    chk(busy === 1'b0 && done === 1'b0 && m_valid === 1'b0, "R1 reset status",
        {29'd0, busy, done, m_valid}, 32'd0);

    run_txn(2'd0, 24'h000000, 1, 8'd0, 100, 0);
    run_txn(2'd1, 24'h123456, 4, 8'd1, 100, 0);
    run_txn(2'd2, 24'hABCDEF, 6, 8'd0, 100, 0);
    run_txn(2'd3, 24'h000010, 2, 8'd2, 100, 0);   // R2 reserved code acts as one lane
    run_txn(2'd2, 24'hFFFFFE, 4, 8'd0, 100, 0);   // R5 address wrap
    run_txn(2'd2, 24'h3C3C3C, 8, 8'd0, 15, 0);    // R8 heavy back-pressure
    run_txn(2'd1, 24'h0F00F0, 5, 8'd3, 100, 1);   // R10 start while busy

    // R10: zero-length request
    @(negedge clk);
    f0 = cs_falls; saw_busy = 0;
    rd_len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy !== 1'b0) saw_busy = 1;
    end
    chk(!saw_busy && cs_falls == f0, "R10 zero length ignored", 32'(saw_busy), 32'd0);

    for (int t = 0; t < 16; t++) begin
      int pick;
      pick = $urandom % 3;
      run_txn(2'($urandom % 4), 24'($urandom), 1 + ($urandom % 8), 8'($urandom % 4),
              (pick == 0) ? 100 : ((pick == 1) ? 60 : 25), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule